// File: doc/BRIEF.md
# Flash Controller With Erase Sequencer

This block fronts a word-addressed non-volatile storage array that is held in on-chip registers. It keeps a main array made of equal pages plus a small separate user-configuration region, and decides, from a two-bit mode register on a simple register bus, whether word writes arriving on a dedicated array write port are stored and whether erase commands are obeyed. Reads use their own combinational read port and are always allowed.

An erase fills its target range with all-ones words. There are three kinds of erase: one page of the main array, the whole main array, or the whole user region. The erase does not finish at once. A walker writes one word per clock, and a status bit shows whether it is still running. While the walker runs, every word write arriving on the array port is dropped. Flash timing, wear and power-loss effects are not modelled.

Register offsets are byte offsets on `reg_addr`: 0x00 mode, 0x04 status, 0x08 and 0x0C page erase, 0x10 main-array erase, 0x14 user-region erase. Mode codes are 0 read-only, 1 write, 2 erase and 3 inert.

Top module: `flashctl`

## Requirements
- R1: The mode register at offset 0x00 comes out of reset as 0. It stores bits [1:0] of any write and reads them back unchanged in bits [1:0], with zeros above, including the value 3.
- R2: Bit 0 of the status register at offset 0x04 reads 1 when no erase is running and 0 while one is running.
- R3: When the mode is 2, writing a byte address to offset 0x08 or 0x0C erases the page that holds that address. The address is aligned down to a PAGE_BYTES boundary, and every word of that page becomes all ones. Words outside the page keep their values.
- R4: When the mode is 2, writing a value with bit 0 set to offset 0x10 sets every word of the main array (NUM_PAGES pages) to all ones.
- R5: When the mode is 2, writing a value with bit 0 set to offset 0x14 sets every word of the user region to all ones.
- R6: When the mode is 1 and no erase is running, a word written on the array port is stored at the address it targets. `arr_user`=0 selects the main array and `arr_user`=1 selects the user region. The word then reads back exactly on the read port.
- R7: An array write is dropped unless the mode held before that clock edge is 1. A mode write in the same cycle has no effect on it.
- R8: Erase commands are dropped unless the mode is 2. They are also dropped while an erase is already running.
- R9: An erase of N words writes one word per clock, so the status bit reads 0 for exactly N cycles. Array writes that arrive during those cycles are dropped.
- R10: A page-erase address at or beyond the main array's size in bytes is ignored, and no erase starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | WORD_W | Register write data |
| reg_rdata | output | WORD_W | Register read data for `reg_addr` (combinational) |
| arr_wr | input | 1 | Array word write strobe |
| arr_user | input | 1 | Write target: 1 user region, 0 main array |
| arr_addr | input | MAIN_AW | Word index of the array write |
| arr_wdata | input | WORD_W | Array write data |
| rd_user | input | 1 | Read target: 1 user region, 0 main array |
| rd_addr | input | MAIN_AW | Word index of the read |
| rd_data | output | WORD_W | Read data (combinational; all ones when the index is out of range) |

## Verification
Two pairs of actions can fall in the same cycle. The first is an array write arriving while the erase walker is writing a word. The bench provokes this by starting a page erase, switching the mode to 1 on the next clock and then presenting an array write inside the erase window. The write must be lost, and the target word must end up all ones. The second is a mode change and an array write in one cycle. The bench drives both together in each direction and judges the outcome only by the mode that held before the edge, through a behavioural model that it compares against the read port and the status bit on every clock.

// File: rtl/flashctl_pkg.sv
package flashctl_pkg;

    typedef enum logic [1:0] {
        MODE_READ  = 2'd0,
        MODE_WRITE = 2'd1,
        MODE_ERASE = 2'd2,
        MODE_INERT = 2'd3
    } mode_e;

    localparam int unsigned OFS_MODE      = 32'h00;
    localparam int unsigned OFS_STATUS    = 32'h04;
    localparam int unsigned OFS_PAGE_BASE = 32'h08;
    localparam int unsigned OFS_WIPE_MAIN = 32'h10;
    localparam int unsigned OFS_WIPE_USER = 32'h14;

endpackage

// File: rtl/flashctl_regs.sv
module flashctl_regs
    import flashctl_pkg::*;
#(
    parameter int WORD_W       = 32,
    parameter int REG_AW       = 5,
    parameter int IDX_W        = 11,
    parameter int PAGE_BYTES   = 16,
    parameter int PAGE_WORDS   = 4,
    parameter int MAIN_WORDS   = 1024,
    parameter int USER_WORDS   = 64,
    parameter int N_PAGE_PORTS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    input  logic              busy_i,
    output logic [1:0]        mode_o,
    output logic              req_o,
    output logic [IDX_W-1:0]  req_first_o,
    output logic [IDX_W-1:0]  req_last_o,
    output logic [WORD_W-1:0] reg_rdata
);

    localparam int BPW        = WORD_W / 8;
    localparam int MAIN_BYTES = MAIN_WORDS * BPW;

    typedef struct packed {
        logic [1:0] mode;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [N_PAGE_PORTS-1:0] page_hit;
    logic [WORD_W-1:0]       page_num;

    for (genvar g = 0; g < N_PAGE_PORTS; g++) begin : g_page_port
        assign page_hit[g] = reg_wr &&
            (reg_addr == REG_AW'(OFS_PAGE_BASE + 4 * g));
    end

    assign page_num = reg_wdata / WORD_W'(PAGE_BYTES);

    always_comb begin
        regs_d      = regs_q;
        req_o       = 1'b0;
        req_first_o = '0;
        req_last_o  = '0;

        if (reg_wr && reg_addr == REG_AW'(OFS_MODE)) begin
            regs_d.mode = reg_wdata[1:0];
        end

        if (regs_q.mode == MODE_ERASE) begin
            if (|page_hit && (reg_wdata < WORD_W'(MAIN_BYTES))) begin
                req_o       = 1'b1;
                req_first_o = IDX_W'(page_num * WORD_W'(PAGE_WORDS));
                req_last_o  = IDX_W'(page_num * WORD_W'(PAGE_WORDS))
                            + IDX_W'(PAGE_WORDS - 1);
            end else if (reg_wr && reg_addr == REG_AW'(OFS_WIPE_MAIN)
                         && reg_wdata[0]) begin
                req_o       = 1'b1;
                req_first_o = '0;
                req_last_o  = IDX_W'(MAIN_WORDS - 1);
            end else if (reg_wr && reg_addr == REG_AW'(OFS_WIPE_USER)
                         && reg_wdata[0]) begin
                req_o       = 1'b1;
                req_first_o = IDX_W'(MAIN_WORDS);
                req_last_o  = IDX_W'(MAIN_WORDS + USER_WORDS - 1);
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == REG_AW'(OFS_MODE)) begin
            reg_rdata = WORD_W'(regs_q.mode);
        end else if (reg_addr == REG_AW'(OFS_STATUS)) begin
            reg_rdata = WORD_W'(!busy_i);
        end
    end

    assign mode_o = regs_q.mode;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{mode: MODE_READ};
        end else begin
            regs_q <= regs_d;
        end
    end

endmodule

// File: rtl/flashctl_erase_seq.sv
module flashctl_erase_seq #(
    parameter int IDX_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [IDX_W-1:0] first_i,
    input  logic [IDX_W-1:0] last_i,
    output logic             busy_o,
    output logic             wipe_en_o,
    output logic [IDX_W-1:0] wipe_idx_o
);

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] ptr;
        logic [IDX_W-1:0] last;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (seq_q.busy) begin
            if (seq_q.ptr == seq_q.last) begin
                seq_d.busy = 1'b0;
            end else begin
                seq_d.ptr = seq_q.ptr + IDX_W'(1);
            end
        end else if (req_i) begin
            seq_d.busy = 1'b1;
            seq_d.ptr  = first_i;
            seq_d.last = last_i;
        end
    end

    assign busy_o     = seq_q.busy;
    assign wipe_en_o  = seq_q.busy;
    assign wipe_idx_o = seq_q.ptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

endmodule

// File: rtl/flashctl_store.sv
module flashctl_store #(
    parameter int WORD_W     = 32,
    parameter int IDX_W      = 11,
    parameter int MAIN_AW    = 10,
    parameter int MAIN_WORDS = 1024,
    parameter int USER_WORDS = 64
) (
    input  logic               clk,
    input  logic               wipe_en,
    input  logic [IDX_W-1:0]   wipe_idx,
    input  logic               wr_req,
    input  logic               wr_allow,
    input  logic               wr_user,
    input  logic [MAIN_AW-1:0] wr_addr,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic               rd_user,
    input  logic [MAIN_AW-1:0] rd_addr,
    output logic [WORD_W-1:0]  rd_data
);

    localparam int TOTAL_WORDS = MAIN_WORDS + USER_WORDS;

    logic [WORD_W-1:0] mem [TOTAL_WORDS];

    logic             main_fit_w, main_fit_r;
    logic             user_fit_w, user_fit_r;
    logic             wr_fit, rd_fit, wr_ok;
    logic [IDX_W-1:0] wr_idx, rd_idx;

    if (MAIN_WORDS == (1 << MAIN_AW)) begin : g_main_full
        assign main_fit_w = 1'b1;
        assign main_fit_r = 1'b1;
    end else begin : g_main_part
        assign main_fit_w = (wr_addr < MAIN_AW'(MAIN_WORDS));
        assign main_fit_r = (rd_addr < MAIN_AW'(MAIN_WORDS));
    end

    assign user_fit_w = ({1'b0, wr_addr} < (MAIN_AW + 1)'(USER_WORDS));
    assign user_fit_r = ({1'b0, rd_addr} < (MAIN_AW + 1)'(USER_WORDS));

    assign wr_fit = wr_user ? user_fit_w : main_fit_w;
    assign rd_fit = rd_user ? user_fit_r : main_fit_r;

    assign wr_idx = wr_user ? IDX_W'(MAIN_WORDS) + IDX_W'(wr_addr)
                            : IDX_W'(wr_addr);
    assign rd_idx = rd_user ? IDX_W'(MAIN_WORDS) + IDX_W'(rd_addr)
                            : IDX_W'(rd_addr);

    assign wr_ok = wr_req && wr_allow && wr_fit;

    always_ff @(posedge clk) begin
        if (wipe_en) begin
            mem[wipe_idx] <= '1;
        end else if (wr_ok) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = rd_fit ? mem[rd_idx] : '1;

endmodule

// File: rtl/flashctl.sv
module flashctl
    import flashctl_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int REG_AW     = 5,
    parameter int PAGE_BYTES = 16,
    parameter int NUM_PAGES  = 256,
    parameter int USER_WORDS = 64,
    localparam int BPW         = WORD_W / 8,
    localparam int PAGE_WORDS  = PAGE_BYTES / BPW,
    localparam int MAIN_WORDS  = NUM_PAGES * PAGE_WORDS,
    localparam int MAIN_AW     = $clog2(MAIN_WORDS),
    localparam int IDX_W       = $clog2(MAIN_WORDS + USER_WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [WORD_W-1:0]  reg_wdata,
    output logic [WORD_W-1:0]  reg_rdata,
    input  logic               arr_wr,
    input  logic               arr_user,
    input  logic [MAIN_AW-1:0] arr_addr,
    input  logic [WORD_W-1:0]  arr_wdata,
    input  logic               rd_user,
    input  logic [MAIN_AW-1:0] rd_addr,
    output logic [WORD_W-1:0]  rd_data
);

    logic [1:0]       mode_q;
    logic             req;
    logic [IDX_W-1:0] req_first, req_last;
    logic             busy, wipe_en;
    logic [IDX_W-1:0] wipe_idx;
    logic             wr_allow;

    flashctl_regs #(
        .WORD_W      (WORD_W),
        .REG_AW      (REG_AW),
        .IDX_W       (IDX_W),
        .PAGE_BYTES  (PAGE_BYTES),
        .PAGE_WORDS  (PAGE_WORDS),
        .MAIN_WORDS  (MAIN_WORDS),
        .USER_WORDS  (USER_WORDS),
        .N_PAGE_PORTS(2)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .busy_i     (busy),
        .mode_o     (mode_q),
        .req_o      (req),
        .req_first_o(req_first),
        .req_last_o (req_last),
        .reg_rdata  (reg_rdata)
    );

    flashctl_erase_seq #(
        .IDX_W(IDX_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req),
        .first_i   (req_first),
        .last_i    (req_last),
        .busy_o    (busy),
        .wipe_en_o (wipe_en),
        .wipe_idx_o(wipe_idx)
    );

    assign wr_allow = (mode_q == MODE_WRITE) && !busy;

    flashctl_store #(
        .WORD_W    (WORD_W),
        .IDX_W     (IDX_W),
        .MAIN_AW   (MAIN_AW),
        .MAIN_WORDS(MAIN_WORDS),
        .USER_WORDS(USER_WORDS)
    ) u_store (
        .clk     (clk),
        .wipe_en (wipe_en),
        .wipe_idx(wipe_idx),
        .wr_req  (arr_wr),
        .wr_allow(wr_allow),
        .wr_user (arr_user),
        .wr_addr (arr_addr),
        .wr_data (arr_wdata),
        .rd_user (rd_user),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/flashctl_chk.sv
module flashctl_chk
    import flashctl_pkg::*;
#(
    parameter int REG_AW     = 5,
    parameter int IDX_W      = 11,
    parameter int PAGE_WORDS = 4,
    parameter int MAIN_WORDS = 1024,
    parameter int USER_WORDS = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic [1:0]        mode_wdata,
    input logic [1:0]        mode_q,
    input logic              busy,
    input logic [IDX_W-1:0]  wipe_idx
);

    logic [IDX_W:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (busy) begin
            run_len <= run_len + (IDX_W + 1)'(1);
        end else begin
            run_len <= '0;
        end
    end

    // R1: a mode write is stored exactly
    a_r1_mode_store: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == REG_AW'(OFS_MODE)) |=> (mode_q == $past(mode_wdata)));

    // R1: without a mode write the mode holds
    a_r1_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == REG_AW'(OFS_MODE)) |=> $stable(mode_q));

    // R8: an erase only starts from a register write in erase mode
    a_r8_erase_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(reg_wr) && $past(mode_q) == MODE_ERASE));

    // R9: the walker advances one word per clock
    a_r9_walk_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (wipe_idx == IDX_W'($past(wipe_idx) + IDX_W'(1))));

    // R3 R4 R5: a finished erase spanned a page, the main array or the user region
    a_r3_erase_span: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == (IDX_W + 1)'(PAGE_WORDS) ||
                         run_len == (IDX_W + 1)'(MAIN_WORDS) ||
                         run_len == (IDX_W + 1)'(USER_WORDS)));

endmodule

bind flashctl flashctl_chk #(
    .REG_AW    (REG_AW),
    .IDX_W     (IDX_W),
    .PAGE_WORDS(PAGE_WORDS),
    .MAIN_WORDS(MAIN_WORDS),
    .USER_WORDS(USER_WORDS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .mode_wdata(reg_wdata[1:0]),
    .mode_q    (mode_q),
    .busy      (busy),
    .wipe_idx  (wipe_idx)
);

// File: tb/flashctl_bench.sv
`timescale 1ns/1ps
module flashctl_bench;

    localparam int MW = 1024;
    localparam int PW = 4;
    localparam int UW = 64;
    localparam logic [31:0] ONES = 32'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = 5'h04;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        arr_wr = 1'b0;
    logic        arr_user = 1'b0;
    logic [9:0]  arr_addr = '0;
    logic [31:0] arr_wdata = '0;
    logic        rd_user = 1'b0;
    logic [9:0]  rd_addr = '0;
    logic [31:0] rd_data;

    always #4 clk = ~clk;

    flashctl u_flashctl (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .arr_wr(arr_wr), .arr_user(arr_user), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
        .rd_user(rd_user), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    string cur_req = "R2";

    int          mode_m = 0;
    bit          busy_m = 0;
    int          wq[$];
    logic [31:0] mem_m [int];

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic int widx(bit u, int a);
        return u ? MW + a : a;
    endfunction

    task automatic model_edge();
        int  m0 = mode_m;
        bit  b0 = busy_m;
        if (b0) begin
            mem_m[wq.pop_front()] = ONES;
            if (wq.size() == 0) busy_m = 0;
        end
        if (arr_wr && m0 == 1 && !b0 && (arr_user ? arr_addr < UW : 1))
            mem_m[widx(arr_user, arr_addr)] = arr_wdata;
        if (reg_wr) begin
            if (reg_addr == 5'h00) mode_m = reg_wdata[1:0];
            if (m0 == 2 && !b0) begin
                if ((reg_addr == 5'h08 || reg_addr == 5'h0C) && reg_wdata < 32'd4096) begin
                    for (int i = 0; i < PW; i++) wq.push_back((reg_wdata / 16) * PW + i);
                    busy_m = 1;
                end else if (reg_addr == 5'h10 && reg_wdata[0]) begin
                    for (int i = 0; i < MW; i++) wq.push_back(i);
                    busy_m = 1;
                end else if (reg_addr == 5'h14 && reg_wdata[0]) begin
                    for (int i = 0; i < UW; i++) wq.push_back(MW + i);
                    busy_m = 1;
                end
            end
        end
    endtask

    task automatic compare();
        int idx = widx(rd_user, rd_addr);
        if (reg_addr == 5'h04)
            chk(reg_rdata[0] == !busy_m, cur_req, {31'd0, reg_rdata[0]}, {31'd0, !busy_m});
        if (reg_addr == 5'h00)
            chk(reg_rdata == 32'(mode_m), "R1", reg_rdata, 32'(mode_m));
        if (mem_m.exists(idx))
            chk(rd_data == mem_m[idx], cur_req, rd_data, mem_m[idx]);
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic reg_write(logic [4:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_addr = 5'h04;
    endtask

    task automatic arr_write(bit u, int a, logic [31:0] d);
        arr_wr = 1'b1; arr_user = u; arr_addr = 10'(a); arr_wdata = d;
        tick();
        arr_wr = 1'b0;
    endtask

    task automatic expect_word(bit u, int a, logic [31:0] exp, string req);
        rd_user = u; rd_addr = 10'(a);
        #1;
        chk(rd_data === exp, req, rd_data, exp);
    endtask

    task automatic expect_reg(logic [4:0] a, logic [31:0] exp, string req);
        reg_addr = a;
        #1;
        chk(reg_rdata === exp, req, reg_rdata, exp);
        reg_addr = 5'h04;
    endtask

    task automatic count_busy(int exp, string req);
        int cnt = 0;
        while (reg_rdata[0] == 1'b0 && cnt < 5000) begin
            tick();
            cnt++;
        end
        chk(cnt == exp, req, 32'(cnt), 32'(exp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog act=timeout exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2: reset state
        expect_reg(5'h00, 32'd0, "R1");
        expect_reg(5'h04, 32'd1, "R2");

        // R1: every code reads back, including 3
        cur_req = "R1";
        reg_write(5'h00, 32'hFFFF_FFF3);
        expect_reg(5'h00, 32'd3, "R1");
        reg_write(5'h00, 32'd0);
        expect_reg(5'h00, 32'd0, "R1");

        // R4 R9: erase of the whole main array, one word per clock
        cur_req = "R4";
        reg_write(5'h00, 32'd2);
        reg_write(5'h10, 32'd1);
        expect_reg(5'h04, 32'd0, "R2");
        count_busy(MW, "R9");
        expect_word(0, 0, ONES, "R4");
        expect_word(0, MW - 1, ONES, "R4");

        // R5: user region erase
        cur_req = "R5";
        reg_write(5'h14, 32'd1);
        count_busy(UW, "R5");
        expect_word(1, 0, ONES, "R5");
        expect_word(1, UW - 1, ONES, "R5");

        // R6: writes in write mode
        cur_req = "R6";
        reg_write(5'h00, 32'd1);
        arr_write(0, 0, 32'hA5A5_0001);
        arr_write(0, MW - 1, 32'hDEAD_BEEF);
        arr_write(1, 0, 32'h0000_0042);
        arr_write(1, UW - 1, 32'h1357_9BDF);
        arr_write(0, 4, 32'h0000_0044);
        for (int i = 8; i < 12; i++) arr_write(0, i, 32'h100 + i);
        arr_write(0, 12, 32'h0000_0077);
        expect_word(0, 0, 32'hA5A5_0001, "R6");
        expect_word(0, MW - 1, 32'hDEAD_BEEF, "R6");
        expect_word(1, 0, 32'h0000_0042, "R6");
        expect_word(1, UW - 1, 32'h1357_9BDF, "R6");
        expect_word(0, 9, 32'h0000_0109, "R6");

        // R7: writes dropped in modes 0, 3 and 2
        cur_req = "R7";
        reg_write(5'h00, 32'd0);
        arr_write(0, 0, 32'h0);
        expect_word(0, 0, 32'hA5A5_0001, "R7");
        reg_write(5'h00, 32'd3);
        arr_write(1, 0, 32'h0);
        expect_word(1, 0, 32'h0000_0042, "R7");
        reg_write(5'h00, 32'd2);
        arr_write(0, MW - 1, 32'h0);
        expect_word(0, MW - 1, 32'hDEAD_BEEF, "R7");

        // R8: erase commands dropped outside erase mode
        cur_req = "R8";
        reg_write(5'h00, 32'd1);
        reg_write(5'h10, 32'd1);
        expect_reg(5'h04, 32'd1, "R8");
        reg_write(5'h08, 32'd0);
        expect_reg(5'h04, 32'd1, "R8");
        tick();
        expect_word(0, 0, 32'hA5A5_0001, "R8");

        // R3: unaligned page address via first page register
        cur_req = "R3";
        reg_write(5'h00, 32'd2);
        reg_write(5'h08, 32'd38);
        count_busy(PW, "R9");
        expect_word(0, 8, ONES, "R3");
        expect_word(0, 11, ONES, "R3");
        expect_word(0, 12, 32'h0000_0077, "R3");
        // R3: second page register erases page 0 only
        reg_write(5'h0C, 32'd0);
        count_busy(PW, "R3");
        expect_word(0, 0, ONES, "R3");
        expect_word(0, 4, 32'h0000_0044, "R3");

        // R10: addresses beyond the array are ignored
        cur_req = "R10";
        reg_write(5'h08, 32'd4096);
        expect_reg(5'h04, 32'd1, "R10");
        reg_write(5'h0C, 32'hFFFF_FFF0);
        expect_reg(5'h04, 32'd1, "R10");
        expect_word(0, MW - 1, 32'hDEAD_BEEF, "R10");

        // R9: array write during an erase is dropped; R8: command while busy dropped
        cur_req = "R9";
        reg_write(5'h0C, 32'd48);
        reg_write(5'h08, 32'd16);
        reg_write(5'h00, 32'd1);
        arr_write(0, 13, 32'h0000_0099);
        while (busy_m) tick();
        tick();
        expect_word(0, 13, ONES, "R9");
        expect_word(0, 4, 32'h0000_0044, "R8");

        // R7: mode change and array write in the same cycle
        cur_req = "R7";
        arr_wr = 1'b1; arr_user = 1'b0; arr_addr = 10'd20; arr_wdata = 32'h00C0_FFEE;
        reg_wr = 1'b1; reg_addr = 5'h00; reg_wdata = 32'd2;
        tick();
        arr_wr = 1'b0; reg_wr = 1'b0; reg_addr = 5'h04;
        expect_word(0, 20, 32'h00C0_FFEE, "R7");
        arr_wr = 1'b1; arr_addr = 10'd21; arr_wdata = 32'h0000_1111;
        reg_wr = 1'b1; reg_addr = 5'h00; reg_wdata = 32'd1;
        tick();
        arr_wr = 1'b0; reg_wr = 1'b0; reg_addr = 5'h04;
        expect_word(0, 21, ONES, "R7");
        expect_reg(5'h00, 32'd1, "R1");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule